// File: doc/BRIEF.md
# Readback Drain DMA Engine

This block moves a run of 128-bit quadwords from a peripheral readback FIFO into memory. Software-side logic hands it a start address and a reserved quadword count with a one-cycle start pulse. The peripheral separately announces how many quadwords it has made ready by adding credit. The engine copies as many quadwords as the credit covers, up to the reservation. It fills the rest of the reserved region with zero quadwords, so memory never keeps stale contents. Credit that the transfer does not use is kept for the next transfer.

Writes leave on a valid/ready beat interface with a 16-byte-aligned address. The address and count registers are visible on the ports and move with every accepted beat. A clamped FIFO-level field, a sticky bus-error flag and a cycle-budget counter report the channel's state. A start whose address is flagged invalid moves no data and completes at once with the error flag set. A one-cycle done pulse closes every transfer.

Top module: `rbk_drain_dma`

## Requirements
- R1: With P the pending credit and N the requested count at start, the first min(P, N) beats carry FIFO words in FIFO order. Each of these beats pops the FIFO exactly once, at the same clock edge that accepts the beat.
- R2: Beats after the credited ones carry data 0. While those zero beats are being sent, `fifo_pop_o` stays 0 even when `fifo_valid_i` is 1.
- R3: The start address is aligned down to a multiple of 16 (its low 4 bits are cleared). Beat i goes to the aligned address + 16*i. After the transfer, `mem_addr_o` holds the aligned address + 16*N, however many beats were credited.
- R4: If P >= N, the pending credit becomes P - N and `fifo_level_o` becomes min(16, P - N). Otherwise both become 0. The new level is visible while `done_o` is 1.
- R5: `qwc_o` loads N at start, drops by 1 on each accepted beat, and reads 0 when `done_o` is 1.
- R6: A start with `addr_fault_i` = 1 sends no beats, sets `bus_err_o`, and forces `qwc_o` and `fifo_level_o` to 0. It leaves the pending credit unchanged, and `done_o` pulses in the cycle after the start. The next start without a fault clears `bus_err_o`.
- R7: `cyc_budget_o` clears at start and grows by 2 per accepted beat, so it ends at 2*N (0 after a fault).
- R8: A beat is accepted when `mem_valid_o` and `mem_ready_i` are both 1, at most one per clock. No beat is offered outside a transfer.
- R9: A start pulse is ignored while a transfer is in progress.
- R10: `done_o` is a one-cycle pulse in the cycle after the last beat is accepted. With N = 0 it comes in the cycle after the start, and no beats are sent.
- R11: `avail_add_i` adds `avail_amt_i` to the pending credit. While idle, `fifo_level_o` then shows min(16, pending credit) from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| start_addr_i | input | ADDR_W | Memory start address (low 4 bits ignored) |
| req_qwc_i | input | QWC_W | Reserved quadword count |
| addr_fault_i | input | 1 | Start address is invalid (sampled with start) |
| avail_add_i | input | 1 | Peripheral adds readback credit |
| avail_amt_i | input | PEND_W | Credit amount added |
| fifo_valid_i | input | 1 | Readback FIFO head is valid |
| fifo_data_i | input | DATA_W | Readback FIFO head quadword |
| fifo_pop_o | output | 1 | Pop the FIFO head |
| mem_valid_o | output | 1 | Write beat valid |
| mem_ready_i | input | 1 | Memory accepts beat |
| mem_addr_o | output | ADDR_W | Address register, beat address |
| mem_data_o | output | DATA_W | Beat data |
| qwc_o | output | QWC_W | Remaining quadword count |
| fifo_level_o | output | $clog2(LVL_MAX+1) | Clamped pending-credit level |
| bus_err_o | output | 1 | Sticky bus-error status |
| cyc_budget_o | output | QWC_W+1 | Timing budget, 2 per beat |
| done_o | output | 1 | Transfer-complete pulse |

## Verification
Some rules hold on every cycle, and the assertions check those. Each accepted beat steps the address by 16, the count by 1 and the budget by 2. A beat that does not pop the FIFO carries zero data, and nothing is popped during the zero phase. Done is a single-cycle pulse with the count at zero, and a fault shows up with done, zero count and zero level. Other behaviour only shows up across whole scenarios, and the bench covers that. The credited/padded split must match min(credit, count), and credit must carry over between transfers and stay untouched by a fault. Late FIFO data must survive a padded transfer. A start pulse in mid-transfer must be ignored, and done must come one cycle after the last beat under stalling ready and FIFO gaps.

// File: rtl/rbk_drain_pkg.sv
`timescale 1ns/1ps
package rbk_drain_pkg;
   typedef enum logic [1:0] {
      DS_IDLE = 2'd0,
      DS_COPY = 2'd1,
      DS_PAD  = 2'd2,
      DS_FIN  = 2'd3
   } drain_st_e;

   localparam int unsigned BUDGET_PER_BEAT = 2;
endpackage

// File: rtl/rbk_credit_track.sv
`timescale 1ns/1ps
module rbk_credit_track #(
   parameter int unsigned PEND_W  = 20,
   parameter int unsigned QWC_W   = 16,
   parameter int unsigned LVL_MAX = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           add_i,
   input  logic [PEND_W-1:0]              add_amt_i,
   input  logic                           busy_i,
   input  logic                           take_i,
   input  logic [QWC_W-1:0]               req_qwc_i,
   input  logic                           lvl_load_i,
   input  logic                           lvl_zero_i,
   output logic [QWC_W-1:0]               copy_n_o,
   output logic [$clog2(LVL_MAX+1)-1:0]   lvl_o
);
   localparam int unsigned LVL_W = $clog2(LVL_MAX + 1);
   localparam int unsigned CMP_W = (PEND_W > QWC_W) ? PEND_W : QWC_W;

   if (LVL_MAX < 1) begin : g_bad_lvl
      $error("rbk_credit_track: LVL_MAX must be at least 1");
   end
   if (PEND_W < 1) begin : g_bad_pend
      $error("rbk_credit_track: PEND_W must be at least 1");
   end

   logic [PEND_W-1:0] pend_q, pend_sum, pend_next;
   logic [CMP_W-1:0]  pend_x, req_x;
   logic              covers;
   logic [LVL_W-1:0]  lvl_q, lvl_next;

   assign pend_sum = pend_q + (add_i ? add_amt_i : '0);
   assign pend_x   = CMP_W'(pend_sum);
   assign req_x    = CMP_W'(req_qwc_i);
   assign covers   = (pend_x >= req_x);

   // credited beats: whole reservation when covered, else every pending word
   assign copy_n_o  = covers ? req_qwc_i : QWC_W'(pend_sum);
   assign pend_next = take_i ? (covers ? (pend_sum - PEND_W'(req_qwc_i)) : '0)
                             : pend_sum;

   // level clamp: pick the cheaper compare depending on relative widths
   if (PEND_W > LVL_W) begin : g_clamp_wide
      assign lvl_next = (pend_next > PEND_W'(LVL_MAX)) ? LVL_W'(LVL_MAX)
                                                         : LVL_W'(pend_next);
   end else begin : g_clamp_narrow
      logic [LVL_W-1:0] pend_narrow;
      assign pend_narrow = LVL_W'(pend_next);
      assign lvl_next = (pend_narrow > LVL_W'(LVL_MAX)) ? LVL_W'(LVL_MAX)
                                                         : pend_narrow;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         lvl_q  <= '0;
      end else begin
         pend_q <= pend_next;
         if (lvl_zero_i) begin
            lvl_q <= '0;
         end else if (lvl_load_i || (add_i && !busy_i)) begin
            lvl_q <= lvl_next;
         end
      end
   end

   assign lvl_o = lvl_q;

   // R4: taking a reservation never grows the credit
   assert_take_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !add_i) |=> (pend_q <= $past(pend_q)));

   // R11: an add while idle with no take leaves credit at least the amount
   assert_add_grows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (add_i && !take_i) |=> (pend_q >= $past(add_amt_i)));
endmodule

// File: rtl/rbk_beat_seq.sv
`timescale 1ns/1ps
module rbk_beat_seq
   import rbk_drain_pkg::*;
#(
   parameter int unsigned QWC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             fault_i,
   input  logic [QWC_W-1:0] req_qwc_i,
   input  logic [QWC_W-1:0] copy_n_i,
   input  logic [QWC_W-1:0] qwc_cur_i,
   input  logic             fire_i,
   output logic             load_o,
   output logic             take_o,
   output logic             lvl_load_o,
   output logic             lvl_zero_o,
   output logic             err_set_o,
   output logic             err_clr_o,
   output logic             in_copy_o,
   output logic             in_pad_o,
   output logic             busy_o,
   output logic             done_o
);
   drain_st_e        state_q, state_d;
   logic [QWC_W-1:0] copy_left_q;
   logic             accept;
   logic             last_beat;

   assign accept    = start_i && (state_q == DS_IDLE);
   assign last_beat = fire_i && (qwc_cur_i == QWC_W'(1));

   always_comb begin
      state_d    = state_q;
      load_o     = 1'b0;
      take_o     = 1'b0;
      lvl_load_o = 1'b0;
      lvl_zero_o = 1'b0;
      err_set_o  = 1'b0;
      err_clr_o  = 1'b0;
      unique case (state_q)
         DS_IDLE: begin
            if (accept) begin
               load_o = 1'b1;
               if (fault_i) begin
                  lvl_zero_o = 1'b1;
                  err_set_o  = 1'b1;
                  state_d    = DS_FIN;
               end else begin
                  take_o    = 1'b1;
                  err_clr_o = 1'b1;
                  if (req_qwc_i == '0) begin
                     lvl_load_o = 1'b1;
                     state_d    = DS_FIN;
                  end else if (copy_n_i != '0) begin
                     state_d = DS_COPY;
                  end else begin
                     state_d = DS_PAD;
                  end
               end
            end
         end
         DS_COPY: begin
            if (last_beat) begin
               lvl_load_o = 1'b1;
               state_d    = DS_FIN;
            end else if (fire_i && (copy_left_q == QWC_W'(1))) begin
               state_d = DS_PAD;
            end
         end
         DS_PAD: begin
            if (last_beat) begin
               lvl_load_o = 1'b1;
               state_d    = DS_FIN;
            end
         end
         default: state_d = DS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= DS_IDLE;
         copy_left_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept && !fault_i) begin
            copy_left_q <= copy_n_i;
         end else if ((state_q == DS_COPY) && fire_i) begin
            copy_left_q <= copy_left_q - QWC_W'(1);
         end
      end
   end

   assign in_copy_o = (state_q == DS_COPY);
   assign in_pad_o  = (state_q == DS_PAD);
   assign busy_o    = (state_q != DS_IDLE);
   assign done_o    = (state_q == DS_FIN);

   // R10: completion is a single-cycle pulse
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R5: count register is empty whenever completion is signalled
   assert_done_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (qwc_cur_i == '0));

   // R9: a start during a running transfer does not end or restart it
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (in_copy_o || in_pad_o) && !fire_i) |=> busy_o && !done_o);
endmodule

// File: rtl/rbk_wr_path.sv
`timescale 1ns/1ps
module rbk_wr_path
   import rbk_drain_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned QWC_W  = 16,
   parameter int unsigned DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              fault_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [QWC_W-1:0]  req_qwc_i,
   input  logic              in_copy_i,
   input  logic              in_pad_i,
   input  logic              fifo_valid_i,
   input  logic [DATA_W-1:0] fifo_data_i,
   input  logic              mem_ready_i,
   output logic              mem_valid_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_data_o,
   output logic              fifo_pop_o,
   output logic              fire_o,
   output logic [QWC_W-1:0]  qwc_o,
   output logic [QWC_W:0]    budget_o
);
   localparam int unsigned STEP  = DATA_W / 8;
   localparam int unsigned LSB_W = $clog2(STEP);

   if ((DATA_W < 8) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_data
      $error("rbk_wr_path: DATA_W must be a power of two of at least 8");
   end
   if (ADDR_W <= LSB_W) begin : g_bad_addr
      $error("rbk_wr_path: ADDR_W too small for the beat size");
   end

   logic [ADDR_W-1:0] aligned;
   logic [ADDR_W-1:0] addr_q;
   logic [QWC_W-1:0]  qwc_q;
   logic [QWC_W:0]    budget_q;

   if (LSB_W > 0) begin : g_align
      assign aligned = {start_addr_i[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
   end else begin : g_noalign
      assign aligned = start_addr_i;
   end

   assign mem_valid_o = in_pad_i || (in_copy_i && fifo_valid_i);
   assign mem_data_o  = in_copy_i ? fifo_data_i : '0;
   assign fifo_pop_o  = in_copy_i && fifo_valid_i && mem_ready_i;
   assign fire_o      = mem_valid_o && mem_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         qwc_q    <= '0;
         budget_q <= '0;
      end else if (load_i) begin
         addr_q   <= aligned;
         qwc_q    <= fault_i ? '0 : req_qwc_i;
         budget_q <= '0;
      end else if (fire_o) begin
         addr_q   <= addr_q + ADDR_W'(STEP);
         qwc_q    <= qwc_q - QWC_W'(1);
         budget_q <= budget_q + (QWC_W+1)'(BUDGET_PER_BEAT);
      end
   end

   assign mem_addr_o = addr_q;
   assign qwc_o      = qwc_q;
   assign budget_o   = budget_q;

   // R3: every accepted beat advances the address by one beat
   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(STEP)));

   // R5: every accepted beat consumes one reserved quadword
   assert_qwc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> (qwc_o == $past(qwc_o) - QWC_W'(1)));

   // R5: no beat is accepted with nothing left reserved
   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> (qwc_o != '0));

   // R7: two budget cycles per accepted beat
   assert_budget_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> (budget_o == $past(budget_o) + (QWC_W+1)'(BUDGET_PER_BEAT)));

   // R2: an accepted beat that does not pop carries zeros
   assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid_o && mem_ready_i && !fifo_pop_o) |-> (mem_data_o == '0));
endmodule

// File: rtl/rbk_drain_dma.sv
`timescale 1ns/1ps
module rbk_drain_dma #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned QWC_W   = 16,
   parameter int unsigned PEND_W  = 20,
   parameter int unsigned LVL_MAX = 16,
   parameter int unsigned DATA_W  = 128
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic [ADDR_W-1:0]             start_addr_i,
   input  logic [QWC_W-1:0]              req_qwc_i,
   input  logic                          addr_fault_i,
   input  logic                          avail_add_i,
   input  logic [PEND_W-1:0]             avail_amt_i,
   input  logic                          fifo_valid_i,
   input  logic [DATA_W-1:0]             fifo_data_i,
   output logic                          fifo_pop_o,
   output logic                          mem_valid_o,
   input  logic                          mem_ready_i,
   output logic [ADDR_W-1:0]             mem_addr_o,
   output logic [DATA_W-1:0]             mem_data_o,
   output logic [QWC_W-1:0]              qwc_o,
   output logic [$clog2(LVL_MAX+1)-1:0]  fifo_level_o,
   output logic                          bus_err_o,
   output logic [QWC_W:0]                cyc_budget_o,
   output logic                          done_o
);
   if (QWC_W < 1) begin : g_bad_qwc
      $error("rbk_drain_dma: QWC_W must be at least 1");
   end

   logic             load, take, lvl_load, lvl_zero, err_set, err_clr;
   logic             in_copy, in_pad, busy, fire;
   logic [QWC_W-1:0] copy_n;
   logic             err_q;

   rbk_credit_track #(
      .PEND_W  (PEND_W),
      .QWC_W   (QWC_W),
      .LVL_MAX (LVL_MAX)
   ) credit_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .add_i      (avail_add_i),
      .add_amt_i  (avail_amt_i),
      .busy_i     (busy),
      .take_i     (take),
      .req_qwc_i  (req_qwc_i),
      .lvl_load_i (lvl_load),
      .lvl_zero_i (lvl_zero),
      .copy_n_o   (copy_n),
      .lvl_o      (fifo_level_o)
   );

   rbk_beat_seq #(
      .QWC_W (QWC_W)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .fault_i    (addr_fault_i),
      .req_qwc_i  (req_qwc_i),
      .copy_n_i   (copy_n),
      .qwc_cur_i  (qwc_o),
      .fire_i     (fire),
      .load_o     (load),
      .take_o     (take),
      .lvl_load_o (lvl_load),
      .lvl_zero_o (lvl_zero),
      .err_set_o  (err_set),
      .err_clr_o  (err_clr),
      .in_copy_o  (in_copy),
      .in_pad_o   (in_pad),
      .busy_o     (busy),
      .done_o     (done_o)
   );

   rbk_wr_path #(
      .ADDR_W (ADDR_W),
      .QWC_W  (QWC_W),
      .DATA_W (DATA_W)
   ) path_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load),
      .fault_i      (addr_fault_i),
      .start_addr_i (start_addr_i),
      .req_qwc_i    (req_qwc_i),
      .in_copy_i    (in_copy),
      .in_pad_i     (in_pad),
      .fifo_valid_i (fifo_valid_i),
      .fifo_data_i  (fifo_data_i),
      .mem_ready_i  (mem_ready_i),
      .mem_valid_o  (mem_valid_o),
      .mem_addr_o   (mem_addr_o),
      .mem_data_o   (mem_data_o),
      .fifo_pop_o   (fifo_pop_o),
      .fire_o       (fire),
      .qwc_o        (qwc_o),
      .budget_o     (cyc_budget_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (err_set) begin
         err_q <= 1'b1;
      end else if (err_clr) begin
         err_q <= 1'b0;
      end
   end

   assign bus_err_o = err_q;

   // R2: the zero phase never draws from the readback FIFO
   assert_pad_no_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_pad |-> !fifo_pop_o);

   // R1: a credited beat accepted always consumes the FIFO head
   assert_copy_pops_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_copy && mem_valid_o && mem_ready_i) |-> fifo_pop_o);

   // R6: an address fault completes at once with count and level cleared
   assert_fault_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_err_o) |-> (done_o && (qwc_o == '0) && (fifo_level_o == '0) && !mem_valid_o));

   // R8: no beat is offered while idle
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_valid_o && !fifo_pop_o));
endmodule

// File: tb/rbk_drain_dma_tb_top.sv
`timescale 1ns/1ps
module rbk_drain_dma_tb_top;
   localparam int AW = 32;
   localparam int QW = 16;
   localparam int PW = 20;
   localparam int DW = 128;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic [AW-1:0]  start_addr_i = '0;
   logic [QW-1:0]  req_qwc_i = '0;
   logic           addr_fault_i = 1'b0;
   logic           avail_add_i = 1'b0;
   logic [PW-1:0]  avail_amt_i = '0;
   logic           fifo_valid_i = 1'b0;
   logic [DW-1:0]  fifo_data_i = '0;
   logic           fifo_pop_o;
   logic           mem_valid_o;
   logic           mem_ready_i = 1'b0;
   logic [AW-1:0]  mem_addr_o;
   logic [DW-1:0]  mem_data_o;
   logic [QW-1:0]  qwc_o;
   logic [4:0]     fifo_level_o;
   logic           bus_err_o;
   logic [QW:0]    cyc_budget_o;
   logic           done_o;

   always #2.5 clk = ~clk;

   rbk_drain_dma dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
      .req_qwc_i(req_qwc_i), .addr_fault_i(addr_fault_i), .avail_add_i(avail_add_i),
      .avail_amt_i(avail_amt_i), .fifo_valid_i(fifo_valid_i), .fifo_data_i(fifo_data_i),
      .fifo_pop_o(fifo_pop_o), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
      .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .qwc_o(qwc_o),
      .fifo_level_o(fifo_level_o), .bus_err_o(bus_err_o), .cyc_budget_o(cyc_budget_o),
      .done_o(done_o)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int last_fire_cyc = -10;
   int pops = 0;
   int pend_m = 0;
   int ready_mode = 0;
   bit gap_mode = 1'b0;
   bit pop_pending = 1'b0;
   bit finished = 1'b0;

   logic [DW-1:0] fifo_q[$];
   logic [AW-1:0] exp_addr[$];
   logic [DW-1:0] exp_data[$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] item(input int n);
      return {4{32'(n) ^ 32'h5A5A_0000}};
   endfunction

   // monitor: drives ready/FIFO away from the edge, pops expected beats
   always @(negedge clk) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      if (pop_pending) begin
         if (fifo_q.size() > 0) void'(fifo_q.pop_front());
         pop_pending = 1'b0;
      end
      case (ready_mode)
         1:       mem_ready_i = ((cyc % 2) == 0);
         2:       mem_ready_i = ((cyc % 3) != 0);
         default: mem_ready_i = 1'b1;
      endcase
      fifo_valid_i = (fifo_q.size() > 0) && !(gap_mode && ((cyc % 4) == 1));
      fifo_data_i  = (fifo_q.size() > 0) ? fifo_q[0] : '0;
      #1;
      if (rst_n && mem_valid_o && mem_ready_i) begin
         if (exp_addr.size() == 0) begin
            check(1'b0, "R8", "unexpected beat", DW'(mem_addr_o), '0);
         end else begin
            a = exp_addr.pop_front();
            d = exp_data.pop_front();
            check(mem_addr_o == a, "R3", "beat address", DW'(mem_addr_o), DW'(a));
            check(mem_data_o == d, "R1,R2", "beat data", mem_data_o, d);
         end
         last_fire_cyc = cyc;
      end
      if (rst_n && fifo_pop_o) begin
         pop_pending = 1'b1;
         pops++;
      end
      cyc++;
   end

   task automatic add_credit(input int n, input int base);
      int lv;
      @(negedge clk);
      avail_add_i = 1'b1;
      avail_amt_i = PW'(n);
      for (int i = 0; i < n; i++) fifo_q.push_back(item(base + i));
      pend_m += n;
      @(negedge clk);
      avail_add_i = 1'b0;
      #2;
      lv = (pend_m > 16) ? 16 : pend_m;
      check(fifo_level_o == 5'(lv), "R11", "level after credit", DW'(fifo_level_o), DW'(lv));
   endtask

   // driver: pushes the expected beats, starts, waits for done, checks registers
   task automatic run_xfer(input logic [AW-1:0] addr, input int n, input bit fault,
                           input bit poke);
      int copy, p0, lv, k;
      logic [AW-1:0] base;
      base = addr & ~32'hF;
      copy = fault ? 0 : ((pend_m < n) ? pend_m : n);
      if (!fault) begin
         for (int i = 0; i < n; i++) begin
            exp_addr.push_back(base + AW'(16 * i));
            exp_data.push_back((i < copy) ? fifo_q[i] : '0);
         end
         pend_m = (pend_m >= n) ? (pend_m - n) : 0;
      end
      lv = fault ? 0 : ((pend_m > 16) ? 16 : pend_m);
      p0 = pops;
      @(negedge clk);
      start_i = 1'b1; start_addr_i = addr; req_qwc_i = QW'(n); addr_fault_i = fault;
      @(negedge clk);
      start_i = 1'b0; addr_fault_i = 1'b0;
      k = 0;
      while (1) begin
         #2;
         if (done_o || (k > 5000)) break;
         k++;
         @(negedge clk);
         if (poke && (k == 2)) begin
            // R9: restart attempt with a fault while busy
            start_i = 1'b1; start_addr_i = 32'hDEAD_0000; req_qwc_i = 16'd3; addr_fault_i = 1'b1;
         end else begin
            start_i = 1'b0; addr_fault_i = 1'b0;
         end
      end
      check(done_o, "R10", "done seen", DW'(done_o), 1);
      if (fault || (n == 0))
         check(k == 0, "R10", "done in cycle after start", DW'(k), 0);
      else
         check((cyc - last_fire_cyc) == 2, "R10", "done one cycle after last beat",
               DW'(cyc - last_fire_cyc), 2);
      check(exp_addr.size() == 0, "R1,R2", "beats outstanding", DW'(exp_addr.size()), 0);
      check(qwc_o == '0, "R5", "count at done", DW'(qwc_o), 0);
      check((pops - p0) == copy, "R1", "fifo pops", DW'(pops - p0), DW'(copy));
      check(mem_addr_o == (fault ? base : base + AW'(16 * n)), "R3", "final address",
            DW'(mem_addr_o), DW'(fault ? base : base + AW'(16 * n)));
      check(fifo_level_o == 5'(lv), "R4", "level at done", DW'(fifo_level_o), DW'(lv));
      check(bus_err_o == fault, "R6", "bus error flag", DW'(bus_err_o), DW'(fault));
      check(cyc_budget_o == (QW+1)'(fault ? 0 : 2 * n), "R7", "budget",
            DW'(cyc_budget_o), DW'(fault ? 0 : 2 * n));
      @(negedge clk);
      #2;
      check(!done_o, "R10", "done single pulse", DW'(done_o), 0);
      check(!mem_valid_o, "R8", "idle after done", DW'(mem_valid_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2;
      check(!mem_valid_o, "R8", "reset valid", DW'(mem_valid_o), 0);
      check(!fifo_pop_o, "R1", "reset pop", DW'(fifo_pop_o), 0);
      check(qwc_o == '0, "R5", "reset count", DW'(qwc_o), 0);
      check(fifo_level_o == '0, "R4", "reset level", DW'(fifo_level_o), 0);
      check(!bus_err_o && !done_o, "R6", "reset error/done", DW'({bus_err_o, done_o}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // credit covers reservation, leftover 2 carried
      ready_mode = 0;
      add_credit(5, 100);
      run_xfer(32'h0000_1000, 3, 1'b0, 1'b0);

      // short credit: 2 copied, 2 zero beats; late FIFO words must stay put
      ready_mode = 1;
      for (int i = 0; i < 3; i++) fifo_q.push_back(item(900 + i));
      run_xfer(32'h0000_2003, 4, 1'b0, 1'b0);
      check(fifo_q.size() == 3, "R2", "late fifo words untouched", DW'(fifo_q.size()), 3);
      @(negedge clk);
      fifo_q.delete();

      // large credit, clamped level, stalling ready
      ready_mode = 2;
      add_credit(40, 200);
      run_xfer(32'h0001_0000, 10, 1'b0, 1'b0);

      // zero-length transfer
      run_xfer(32'h0002_0000, 0, 1'b0, 1'b0);

      // address fault: credit must survive
      run_xfer(32'h0003_0000, 7, 1'b1, 1'b0);

      // start poked mid-transfer is ignored, error cleared by clean start
      ready_mode = 1;
      run_xfer(32'h0004_0000, 6, 1'b0, 1'b1);

      // FIFO gaps, credit 24 of 30
      ready_mode = 0;
      gap_mode = 1'b1;
      run_xfer(32'h0005_0040, 30, 1'b0, 1'b0);
      gap_mode = 1'b0;
      check(fifo_q.size() == 0, "R1", "fifo drained", DW'(fifo_q.size()), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule